// File: doc/BRIEF.md
# Thermal line print transfer sequencer

This block sits between a CPU bus and a thermal line head. Software, or a DMA controller that it paces with a one-byte request pulse, writes the print bytes of one dot line into a small line buffer. Once the buffer holds a whole line, the block turns the bytes into a serial stream. It clocks them into the head at half the system clock and ends the transfer with a one-cycle latch pulse.

A start command then drives the head strobe for that line. The strobe can have two phases. An optional pre-pulse comes first, selected by a mode field, and the same line is shifted into the head a second time while it runs. The main pulse follows. While the main pulse heats the current line, the buffer is already free for the next line, and that line is shifted in during the strobe. Its latch pulse is held back until the strobe ends. The strobe sequence waits for a paper-feed-complete input before it starts. Both phase widths are programmable in system clock cycles.

Top module: `tlp_seq`

## Requirements
- R1: A write of 0xFF to offset 1 raises `drq` for exactly one cycle, on the clock after the write. A write of any other value to offset 1 leaves `drq` low.
- R2: Bytes written to offset 0 fill a line buffer of LINE_BYTES entries. When the buffer is full, the bytes go out in write order, most significant bit first. Each bit is driven on `hd_dat` for one cycle with `hd_clk` low and then one cycle with `hd_clk` high.
- R3: Byte writes to offset 0 made after the buffer is full are ignored. After the last bit of a line, `hd_lat` pulses for one cycle, and never while `stb` is high.
- R4: Offset 2 bits [1:0] hold the mode. The value 01 enables a pre-pulse before the main pulse. Any other value gives the main pulse alone.
- R5: The pre-pulse width is set at offsets 3 (low byte) and 4 (high byte), and the main-pulse width at offsets 5 and 6. Each phase holds `stb` high for exactly that many cycles, and a width of 0 gives 1 cycle. `stb_pre` is high only during the pre-pulse.
- R6: During the pre-pulse, the same line is shifted to the head again. It is latched in a gap with `stb` low, and the main pulse follows.
- R7: When the main pulse starts, the line buffer is freed. The next line's bytes are accepted and shifted while `stb` is high, and their latch pulse comes only after the main pulse ends.
- R8: Writing offset 7 with bit 0 set starts a strobe sequence. The first phase begins only once the line is latched and `feed_ok` is high. The pre-pulse never starts without `feed_ok`.
- R9: A start written while a sequence is pending or strobing is ignored and sets the error flag. Reading offset 7 returns bit 0 = strobe active, bit 1 = error, and bit 2 = line latched and ready. Writing offset 7 with bit 1 set clears the error.
- R10: After reset, `drq`, `hd_clk`, `hd_dat`, `hd_lat`, `stb` and `stb_pre` are low and the status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | Write strobe, one cycle per write |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr`, combinational |
| drq | output | 1 | One-byte DMA request pulse |
| feed_ok | input | 1 | Paper feed complete |
| hd_clk | output | 1 | Head shift clock |
| hd_dat | output | 1 | Head serial data |
| hd_lat | output | 1 | Head latch pulse |
| stb | output | 1 | Head strobe, both phases |
| stb_pre | output | 1 | High during the pre-pulse phase |

## Verification
The sequence is exercised with several line patterns. These include alternating, sparse, all-ones/all-zeros and asymmetric bytes, so that a reversed bit or byte order, or a dropped bit, gives a different latched word. The patterns are paired with the pre-pulse enabled, with the mode set to a non-enable value, and with widths of 0, 1 and values above 255, which separates a correct mode decode from a loose one and a full-width counter from one limited to the low byte. One directed case writes the next line during a long main pulse and issues a stray start there. This separates true overlap and a deferred latch from serialised transfer, and shows whether the error path restarts the strobe.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

   localparam logic [2:0] OFS_DATA  = 3'd0;
   localparam logic [2:0] OFS_DMA   = 3'd1;
   localparam logic [2:0] OFS_MODE  = 3'd2;
   localparam logic [2:0] OFS_PRE_L = 3'd3;
   localparam logic [2:0] OFS_PRE_H = 3'd4;
   localparam logic [2:0] OFS_MN_L  = 3'd5;
   localparam logic [2:0] OFS_MN_H  = 3'd6;
   localparam logic [2:0] OFS_CTRL  = 3'd7;

   localparam logic [1:0] MODE_PRE_ON = 2'b01;
   localparam logic [7:0] DMA_KEY     = 8'hFF;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_PRE,
      ST_GAP,
      ST_MAIN
   } tlp_state_e;

endpackage

// File: rtl/tlp_regs.sv
module tlp_regs
   import tlp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   input  logic [2:0]       status,
   output logic             drq,
   output logic             buf_we,
   output logic             go,
   output logic             clr_err,
   output logic             pre_en,
   output logic [CNT_W-1:0] pre_w,
   output logic [CNT_W-1:0] main_w
);

   localparam int HW = CNT_W - 8;

   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt_w
         $error("tlp_regs: CNT_W must lie in 9..16");
      end
   endgenerate

   logic [1:0]    mode_q;
   logic [7:0]    pre_lo_q, main_lo_q;
   logic [HW-1:0] pre_hi_q, main_hi_q;
   logic          drq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         pre_lo_q  <= '0;
         pre_hi_q  <= '0;
         main_lo_q <= '0;
         main_hi_q <= '0;
         drq_q     <= 1'b0;
      end else begin
         drq_q <= we && (addr == OFS_DMA) && (wdata == DMA_KEY);
         if (we) begin
            case (addr)
               OFS_MODE:  mode_q    <= wdata[1:0];
               OFS_PRE_L: pre_lo_q  <= wdata;
               OFS_PRE_H: pre_hi_q  <= wdata[HW-1:0];
               OFS_MN_L:  main_lo_q <= wdata;
               OFS_MN_H:  main_hi_q <= wdata[HW-1:0];
               default:   ;
            endcase
         end
      end
   end

   assign drq     = drq_q;
   assign buf_we  = we && (addr == OFS_DATA);
   assign go      = we && (addr == OFS_CTRL) && wdata[0];
   assign clr_err = we && (addr == OFS_CTRL) && wdata[1];
   assign pre_en  = (mode_q == MODE_PRE_ON);
   assign pre_w   = {pre_hi_q, pre_lo_q};
   assign main_w  = {main_hi_q, main_lo_q};

   always_comb begin
      case (addr)
         OFS_MODE:  rdata = {6'd0, mode_q};
         OFS_PRE_L: rdata = pre_lo_q;
         OFS_PRE_H: rdata = 8'(pre_hi_q);
         OFS_MN_L:  rdata = main_lo_q;
         OFS_MN_H:  rdata = 8'(main_hi_q);
         OFS_CTRL:  rdata = {5'd0, status};
         default:   rdata = 8'd0;
      endcase
   end

endmodule

// File: rtl/tlp_linebuf.sv
module tlp_linebuf #(
   parameter int BYTES = 4,
   localparam int IW = $clog2(BYTES),
   localparam int PW = $clog2(BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [7:0]    wdata,
   input  logic          rel,
   input  logic [IW-1:0] rd_idx,
   output logic [7:0]    rd_byte,
   output logic          full
);

   generate
      if (BYTES < 2 || BYTES > 256) begin : g_bad_bytes
         $error("tlp_linebuf: BYTES must lie in 2..256");
      end
   endgenerate

   logic [7:0]    mem [BYTES];
   logic [PW-1:0] wptr_q;

   assign full    = (wptr_q == PW'(BYTES));
   assign rd_byte = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
      end else if (rel) begin
         wptr_q <= we ? PW'(1) : '0;
      end else if (we && !full) begin
         wptr_q <= wptr_q + PW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rel && we) begin
         mem[0] <= wdata;
      end else if (we && !full) begin
         mem[wptr_q[IW-1:0]] <= wdata;
      end
   end

endmodule

// File: rtl/tlp_shift.sv
module tlp_shift #(
   parameter int BYTES     = 4,
   parameter bit MSB_FIRST = 1'b1,
   localparam int TOT = BYTES * 16,
   localparam int CW  = $clog2(TOT),
   localparam int IW  = $clog2(BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [7:0]    rd_byte,
   output logic [IW-1:0] rd_idx,
   output logic          hd_clk,
   output logic          hd_dat,
   output logic          busy,
   output logic          done
);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          last;
   logic [2:0]    bit_sel;
   logic          pick;

   assign last    = (cnt_q == CW'(TOT - 1));
   assign bit_sel = cnt_q[3:1];
   assign rd_idx  = IW'(cnt_q >> 4);

   generate
      if (MSB_FIRST) begin : g_msb
         assign pick = rd_byte[3'd7 - bit_sel];
      end else begin : g_lsb
         assign pick = rd_byte[bit_sel];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end else if (last) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign busy   = busy_q;
   assign done   = busy_q && last;
   assign hd_clk = busy_q && cnt_q[0];
   assign hd_dat = busy_q && pick;

endmodule

// File: rtl/tlp_ctrl.sv
module tlp_ctrl
   import tlp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             clr_err,
   input  logic             pre_en,
   input  logic [CNT_W-1:0] pre_w,
   input  logic [CNT_W-1:0] main_w,
   input  logic             feed_ok,
   input  logic             buf_full,
   input  logic             sh_busy,
   input  logic             sh_done,
   output logic             sh_start,
   output logic             buf_rel,
   output logic             hd_lat,
   output logic             stb,
   output logic             stb_pre,
   output logic             err,
   output logic             line_rdy
);

   tlp_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             err_q, head_ok_q, pend_q, sha_q, shifted_q;
   logic             idle_like, trig_a, sh_again, lat_norm, lat_gap;

   assign idle_like = (state_q == ST_IDLE) || (state_q == ST_WAIT);
   assign trig_a    = buf_full && !shifted_q && !sh_busy && !pend_q && !head_ok_q
                      && (state_q != ST_PRE) && (state_q != ST_GAP);
   assign lat_norm  = pend_q && idle_like;

   always_comb begin
      state_d  = state_q;
      cnt_d    = cnt_q;
      sh_again = 1'b0;
      buf_rel  = 1'b0;
      lat_gap  = 1'b0;
      case (state_q)
         ST_IDLE: if (go) state_d = ST_WAIT;
         ST_WAIT: begin
            if (head_ok_q && feed_ok) begin
               if (pre_en) begin
                  state_d  = ST_PRE;
                  cnt_d    = pre_w;
                  sh_again = 1'b1;
               end else begin
                  state_d = ST_MAIN;
                  cnt_d   = main_w;
                  buf_rel = 1'b1;
               end
            end
         end
         ST_PRE: begin
            if (cnt_q <= CNT_W'(1)) state_d = ST_GAP;
            else                    cnt_d   = cnt_q - CNT_W'(1);
         end
         ST_GAP: begin
            if (!sh_busy) begin
               lat_gap = 1'b1;
               state_d = ST_MAIN;
               cnt_d   = main_w;
               buf_rel = 1'b1;
            end
         end
         ST_MAIN: begin
            if (cnt_q <= CNT_W'(1)) state_d = ST_IDLE;
            else                    cnt_d   = cnt_q - CNT_W'(1);
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         err_q     <= 1'b0;
         head_ok_q <= 1'b0;
         pend_q    <= 1'b0;
         sha_q     <= 1'b0;
         shifted_q <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         if (go && (state_q != ST_IDLE)) err_q <= 1'b1;
         else if (clr_err)               err_q <= 1'b0;
         if (buf_rel)       head_ok_q <= 1'b0;
         else if (lat_norm) head_ok_q <= 1'b1;
         if (lat_norm)              pend_q <= 1'b0;
         else if (sh_done && sha_q) pend_q <= 1'b1;
         if (trig_a)       sha_q <= 1'b1;
         else if (sh_done) sha_q <= 1'b0;
         if (buf_rel)     shifted_q <= 1'b0;
         else if (trig_a) shifted_q <= 1'b1;
      end
   end

   assign sh_start = trig_a || sh_again;
   assign hd_lat   = lat_norm || lat_gap;
   assign stb      = (state_q == ST_PRE) || (state_q == ST_MAIN);
   assign stb_pre  = (state_q == ST_PRE);
   assign err      = err_q;
   assign line_rdy = head_ok_q;

endmodule

// File: rtl/tlp_seq.sv
module tlp_seq #(
   parameter int LINE_BYTES = 4,
   parameter int CNT_W      = 16,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_we,
   input  logic [2:0] cpu_addr,
   input  logic [7:0] cpu_wdata,
   output logic [7:0] cpu_rdata,
   output logic       drq,
   input  logic       feed_ok,
   output logic       hd_clk,
   output logic       hd_dat,
   output logic       hd_lat,
   output logic       stb,
   output logic       stb_pre
);

   localparam int IW = $clog2(LINE_BYTES);

   logic             buf_we, go, clr_err, pre_en;
   logic [CNT_W-1:0] pre_w, main_w;
   logic             buf_full, buf_rel;
   logic [IW-1:0]    rd_idx;
   logic [7:0]       rd_byte;
   logic             sh_start, sh_busy, sh_done;
   logic             err, line_rdy;
   logic [2:0]       status;

   assign status = {line_rdy, err, stb};

   tlp_regs #(.CNT_W(CNT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cpu_we),
      .addr    (cpu_addr),
      .wdata   (cpu_wdata),
      .rdata   (cpu_rdata),
      .status  (status),
      .drq     (drq),
      .buf_we  (buf_we),
      .go      (go),
      .clr_err (clr_err),
      .pre_en  (pre_en),
      .pre_w   (pre_w),
      .main_w  (main_w)
   );

   tlp_linebuf #(.BYTES(LINE_BYTES)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (buf_we),
      .wdata   (cpu_wdata),
      .rel     (buf_rel),
      .rd_idx  (rd_idx),
      .rd_byte (rd_byte),
      .full    (buf_full)
   );

   tlp_shift #(.BYTES(LINE_BYTES), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sh_start),
      .rd_byte (rd_byte),
      .rd_idx  (rd_idx),
      .hd_clk  (hd_clk),
      .hd_dat  (hd_dat),
      .busy    (sh_busy),
      .done    (sh_done)
   );

   tlp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .clr_err  (clr_err),
      .pre_en   (pre_en),
      .pre_w    (pre_w),
      .main_w   (main_w),
      .feed_ok  (feed_ok),
      .buf_full (buf_full),
      .sh_busy  (sh_busy),
      .sh_done  (sh_done),
      .sh_start (sh_start),
      .buf_rel  (buf_rel),
      .hd_lat   (hd_lat),
      .stb      (stb),
      .stb_pre  (stb_pre),
      .err      (err),
      .line_rdy (line_rdy)
   );

endmodule

// File: rtl/tlp_seq_chk.sv
module tlp_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_we,
   input logic [2:0] cpu_addr,
   input logic [7:0] cpu_wdata,
   input logic [7:0] cpu_rdata,
   input logic       drq,
   input logic       feed_ok,
   input logic       hd_clk,
   input logic       hd_lat,
   input logic       stb,
   input logic       stb_pre
);

   AST_DRQ_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      drq |-> $past(cpu_we && cpu_addr == 3'd1 && cpu_wdata == 8'hFF)); // R1

   AST_DRQ_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_addr == 3'd1 && cpu_wdata == 8'hFF) |=> drq); // R1

   AST_HCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      hd_clk |=> !hd_clk); // R2

   AST_LAT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      hd_lat |-> !stb); // R3

   AST_PRE_GAP_BEFORE_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stb_pre) |-> !stb); // R6

   AST_PRE_NEEDS_FEED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stb_pre) |-> $past(feed_ok)); // R8

   AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr == 3'd7) |-> (cpu_rdata[0] == stb)); // R9

endmodule

bind tlp_seq tlp_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_we    (cpu_we),
   .cpu_addr  (cpu_addr),
   .cpu_wdata (cpu_wdata),
   .cpu_rdata (cpu_rdata),
   .drq       (drq),
   .feed_ok   (feed_ok),
   .hd_clk    (hd_clk),
   .hd_lat    (hd_lat),
   .stb       (stb),
   .stb_pre   (stb_pre)
);

// File: tb/tlp_seq_bench.sv
module tlp_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_we = 1'b0;
   logic [2:0] cpu_addr = 3'd0;
   logic [7:0] cpu_wdata = 8'd0;
   logic [7:0] cpu_rdata;
   logic       drq, feed_ok, hd_clk, hd_dat, hd_lat, stb, stb_pre;

   int checks = 0;
   int errors = 0;

   int          drq_cnt = 0, lat_cnt = 0, pre_run = 0, main_run = 0;
   int          clk_in_stb = 0, lat_in_stb = 0;
   logic [31:0] shreg = '0, latched = '0;

   always #10 clk = ~clk;

   tlp_seq u_tlp_seq (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .drq(drq), .feed_ok(feed_ok),
      .hd_clk(hd_clk), .hd_dat(hd_dat), .hd_lat(hd_lat), .stb(stb), .stb_pre(stb_pre)
   );

   // head and strobe observer, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (drq) drq_cnt++;
         if (hd_clk) shreg = {shreg[30:0], hd_dat};
         if (hd_clk && stb) clk_in_stb++;
         if (hd_lat) begin
            latched = shreg;
            lat_cnt++;
            if (stb) lat_in_stb++;
         end
         if (stb_pre) pre_run++;
         if (stb && !stb_pre) main_run++;
      end
   end

   typedef struct packed {
      logic [31:0] pat;
      logic [1:0]  mode;
      logic [15:0] pre_w;
      logic [15:0] main_w;
      logic [15:0] exp_pre;
      logic [15:0] exp_main;
   } vec_t;

   localparam int NVEC = 4;
   localparam vec_t VEC [NVEC] = '{
      '{32'hA53C0F81, 2'b01, 16'd10, 16'd20,  16'd10, 16'd20},
      '{32'h12345678, 2'b00, 16'd10, 16'd35,  16'd0,  16'd35},
      '{32'hFF008001, 2'b01, 16'd1,  16'd0,   16'd1,  16'd1},
      '{32'hC39669E7, 2'b11, 16'd5,  16'd300, 16'd0,  16'd300}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      cpu_addr = a;
      #2;
      d = cpu_rdata;
   endtask

   task automatic wait_lat(input int target);
      for (int i = 0; i < 600 && lat_cnt < target; i++) begin
         @(negedge clk); #2;
      end
   endtask

   task automatic wait_seq_end();
      for (int i = 0; i < 3000 && !(main_run > 0 && !stb); i++) begin
         @(negedge clk); #2;
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] st;
      int         l0, d0;
      feed_ok = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;

      // R10: reset state
      chk({drq, hd_clk, hd_dat, hd_lat, stb, stb_pre} == 6'd0, "R10 outputs",
          {26'd0, drq, hd_clk, hd_dat, hd_lat, stb, stb_pre}, 32'd0);
      rd(3'd7, st);
      chk(st == 8'd0, "R10 status", st, 32'd0);

      // R1: DMA request pulse
      d0 = drq_cnt;
      wr(3'd1, 8'hFF);
      #2;
      chk(drq == 1'b1, "R1 drq level after key", drq, 32'd1);
      repeat (3) @(negedge clk);
      chk(drq_cnt == d0 + 1, "R1 single pulse", drq_cnt, d0 + 1);
      wr(3'd1, 8'h7F);
      repeat (3) @(negedge clk);
      chk(drq_cnt == d0 + 1, "R1 other value no pulse", drq_cnt, d0 + 1);

      // table of lines walked by one loop
      for (int v = 0; v < NVEC; v++) begin
         feed_ok = 1'b0;
         wr(3'd2, {6'd0, VEC[v].mode});
         wr(3'd3, VEC[v].pre_w[7:0]);
         wr(3'd4, VEC[v].pre_w[15:8]);
         wr(3'd5, VEC[v].main_w[7:0]);
         wr(3'd6, VEC[v].main_w[15:8]);
         l0 = lat_cnt;
         for (int b = 3; b >= 0; b--) wr(3'd0, VEC[v].pat[b*8 +: 8]);
         wait_lat(l0 + 1);
         chk(latched == VEC[v].pat, "R2 serial line", latched, VEC[v].pat);
         repeat (2) @(negedge clk);
         rd(3'd7, st);
         chk(st[2] == 1'b1, "R9 line ready bit", st, 32'd4);
         pre_run = 0; main_run = 0;
         wr(3'd7, 8'h01);
         repeat (10) @(negedge clk);
         #2;
         chk(stb == 1'b0 && pre_run == 0, "R8 waits for feed", stb, 32'd0);
         feed_ok = 1'b1;
         wait_seq_end();
         chk(pre_run == VEC[v].exp_pre, "R4 R5 pre width", pre_run, VEC[v].exp_pre);
         chk(main_run == VEC[v].exp_main, "R5 main width", main_run, VEC[v].exp_main);
         chk(lat_cnt == l0 + 1 + ((VEC[v].exp_pre != 0) ? 1 : 0), "R6 relatch count",
             lat_cnt, l0 + 1 + ((VEC[v].exp_pre != 0) ? 1 : 0));
         chk(latched == VEC[v].pat, "R6 relatched data", latched, VEC[v].pat);
         feed_ok = 1'b0;
      end

      // R3: extra byte ignored
      wr(3'd2, 8'h00);
      wr(3'd5, 8'h90);
      wr(3'd6, 8'h01);
      l0 = lat_cnt;
      wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33); wr(3'd0, 8'h44);
      wr(3'd0, 8'h55);
      wait_lat(l0 + 1);
      chk(latched == 32'h11223344, "R3 fifth byte ignored", latched, 32'h11223344);

      // R7 and R9: overlap of next line with main pulse, stray start
      feed_ok = 1'b1;
      pre_run = 0; main_run = 0; clk_in_stb = 0;
      wr(3'd7, 8'h01);
      for (int i = 0; i < 20 && !stb; i++) @(negedge clk);
      l0 = lat_cnt;
      wr(3'd0, 8'hDE); wr(3'd0, 8'hAD); wr(3'd0, 8'hBE); wr(3'd0, 8'hEF);
      wr(3'd7, 8'h01);
      rd(3'd7, st);
      chk(st[1:0] == 2'b11, "R9 error on start while strobing", st, 32'd3);
      repeat (100) @(negedge clk);
      #2;
      chk(clk_in_stb == 32, "R7 shift during main", clk_in_stb, 32'd32);
      chk(lat_cnt == l0, "R7 latch deferred", lat_cnt, l0);
      wait_seq_end();
      chk(main_run == 400, "R9 stray start no restart", main_run, 32'd400);
      wait_lat(l0 + 1);
      chk(latched == 32'hDEADBEEF, "R7 next line latched", latched, 32'hDEADBEEF);
      chk(lat_in_stb == 0, "R3 no latch in strobe", lat_in_stb, 32'd0);
      wr(3'd7, 8'h02);
      rd(3'd7, st);
      chk(st[1] == 1'b0, "R9 error cleared", st, 32'd4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule